// File: doc/BRIEF.md
# UART Register Front-End with Receive Byte Queue

This block is the bus-facing register set of a simple serial port. A processor reaches it through an APB slave port. It offers a data port, a status word that can only be read, a control word that can be read and written, and a scaler slot that accepts accesses but has no effect. Received bytes come in on a valid/ready byte stream and are held in an internal queue. The processor drains that queue by reading the data port. A write to the data port sends a single-cycle strobe with one byte toward a serial engine outside the block. The block treats its transmit side as always empty.

The receive queue does not work as a circular buffer. A write index and a read index both move forward, and the space a read frees is not given back until every stored byte has been read. At that point both indices return to zero. The free-space output shows this, and the producer uses it for flow control. One interrupt output gives a one-cycle pulse when a byte is stored or when a byte is sent, provided the interrupt enable for that direction is set.

Top module: `urf_apb_top`

## Requirements
- R1: After reset, status reads 0x0000_0006 (transmit-shift-empty bit 1 and transmit-queue-empty bit 2 set, all other bits clear). Control reads 0. `rx_free` equals the queue depth (1024). `irq` and `tx_valid` are low.
- R2: Control (offset 0x08) holds all 32 bits exactly as written and reads them back. It changes only when control is written.
- R3: Writes to status (0x04), scaler (0x0C), the debug slot (0x10) and unmapped offsets have no effect. Reads of scaler, the debug slot and unmapped offsets return 0.
- R4: A byte is taken off the stream when `rx_valid` and `rx_ready` are both high. The byte is stored only if control bit 0 (receive enable) is set. Each stored byte lowers `rx_free` by one and sets status bit 0 (data ready). A byte taken while receive enable is clear is dropped.
- R5: In the access phase, a read at offset 0x00 or 0x03 returns the oldest unread byte in bits 7:0 with zeros above it. The read also moves on to the next byte.
- R6: Reads do not give space back until the last stored byte has been read. At that read, `rx_free` returns to the full depth and data ready clears. A byte that arrives in the same cycle as that last read is stored as the only entry.
- R7: A data-port read while no byte is waiting returns 0 and leaves data ready clear.
- R8: `rx_ready` is low exactly when `rx_free` is 0.
- R9: An access-phase write at offset 0x00 or 0x03 while control bit 1 (transmit enable) is set makes `tx_valid` high for one cycle in the next cycle, with `tx_byte` equal to `pwdata[7:0]`. With transmit enable clear, there is no strobe.
- R10: `irq` goes high for one cycle in the cycle after a byte is stored while control bit 2 is set. It also does so after a transmitted write while control bit 3 is set. It stays low at all other times.
- R11: Only `paddr[7:0]` is decoded. Addresses that differ only above bit 7 reach the same register.
- R12: `pready` is always high and `pslverr` is always low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | ADDR_W | APB byte address; low 8 bits decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always high |
| pslverr | output | 1 | Always low |
| rx_valid | input | 1 | Incoming byte offered |
| rx_data | input | 8 | Incoming byte |
| rx_ready | output | 1 | Queue can take a byte |
| rx_free | output | clog2(FIFO_DEPTH+1) | Free slots in the receive queue |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_byte | output | 8 | Byte to transmit |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The receive queue is driven with several traffic patterns. Single bytes drained one at a time catch mistakes in the index reset. A burst drained part-way, using both data-port offsets, shows that partial reads give back no space. A byte that lands in the same cycle as the draining read separates "flush then store" from "store then flush". A continuous stream of more than the depth checks the back-pressure edge. Transmit writes are tried with every mix of the two enable bits and at both data offsets, so that strobes and interrupt pulses are matched to their cause. Control writes use all-ones and mixed words to expose any bit that does not hold.

// File: rtl/urf_pkg.sv
package urf_pkg;

    localparam int WORD_W     = 32;
    localparam int BYTE_W     = 8;
    localparam int OFS_W      = 8;

    // Decoded byte offsets within the register window
    localparam logic [OFS_W-1:0] OFS_DATA   = 8'h00;
    localparam logic [OFS_W-1:0] OFS_DATA_B = 8'h03;
    localparam logic [OFS_W-1:0] OFS_STAT   = 8'h04;
    localparam logic [OFS_W-1:0] OFS_CTRL   = 8'h08;
    localparam logic [OFS_W-1:0] OFS_SCALE  = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_DBG    = 8'h10;

    // Control bit positions that the front-end acts on
    localparam int CB_RX_EN = 0;
    localparam int CB_TX_EN = 1;
    localparam int CB_RX_IE = 2;
    localparam int CB_TX_IE = 3;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_DATA,
        SEL_STAT,
        SEL_CTRL,
        SEL_SCALE,
        SEL_DBG
    } reg_sel_e;

    // Status word, bit 0 at the right
    typedef struct packed {
        logic [20:0] rsvd;
        logic        rxq_full;
        logic        txq_full;
        logic        rxq_half;
        logic        txq_half;
        logic        frame_err;
        logic        par_err;
        logic        overrun;
        logic        brk;
        logic        txq_empty;
        logic        tx_shift_empty;
        logic        rx_avail;
    } stat_t;

    typedef struct packed {
        reg_sel_e sel;
        logic     rd_strobe;
        logic     rd_data;
        logic     wr_data;
        logic     wr_ctrl;
    } acc_t;

    function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] ofs);
        reg_sel_e s;
        case (ofs)
            OFS_DATA, OFS_DATA_B: s = SEL_DATA;
            OFS_STAT:             s = SEL_STAT;
            OFS_CTRL:             s = SEL_CTRL;
            OFS_SCALE:            s = SEL_SCALE;
            OFS_DBG:              s = SEL_DBG;
            default:              s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic stat_t build_status(input logic rx_avail);
        stat_t s;
        s                = '0;
        s.tx_shift_empty = 1'b1;
        s.txq_empty      = 1'b1;
        s.rx_avail       = rx_avail;
        return s;
    endfunction

endpackage

// File: rtl/urf_addr_decode.sv
module urf_addr_decode
    import urf_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    output acc_t              acc
);

    logic unused_addr_hi;
    logic access;

    generate
        if (ADDR_W > OFS_W) begin : g_hi
            assign unused_addr_hi = ^paddr[ADDR_W-1:OFS_W];
        end else begin : g_nohi
            assign unused_addr_hi = 1'b0;
        end
    endgenerate

    assign access = psel && penable;

    always_comb begin
        acc           = '0;
        acc.sel       = decode_ofs(paddr[OFS_W-1:0]);
        acc.rd_strobe = psel && !pwrite;
        acc.rd_data   = access && !pwrite && (acc.sel == SEL_DATA);
        acc.wr_data   = access &&  pwrite && (acc.sel == SEL_DATA);
        acc.wr_ctrl   = access &&  pwrite && (acc.sel == SEL_CTRL);
    end

endmodule

// File: rtl/urf_rx_fifo.sv
module urf_rx_fifo #(
    parameter int DEPTH = 1024,
    parameter int W     = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [W-1:0]               push_byte,
    input  logic                       pop,
    output logic [W-1:0]               head_byte,
    output logic                       has_data,
    output logic                       drain,
    output logic [$clog2(DEPTH+1)-1:0] free
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] len_q;
    logic [CNT_W-1:0] cur_q;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] rd_idx;

    assign has_data = cur_q < len_q;
    assign drain    = pop && has_data && ((cur_q + CNT_W'(1)) == len_q);
    assign wr_idx   = drain ? '0 : len_q[IDX_W-1:0];
    assign rd_idx   = cur_q[IDX_W-1:0];
    assign free     = CNT_W'(DEPTH) - len_q;
    assign head_byte = has_data ? mem[rd_idx] : '0;

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_idx] <= push_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            len_q <= '0;
            cur_q <= '0;
        end else if (drain) begin
            cur_q <= '0;
            len_q <= push ? CNT_W'(1) : '0;
        end else begin
            if (pop && has_data) begin
                cur_q <= cur_q + CNT_W'(1);
            end
            if (push) begin
                len_q <= len_q + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/urf_tx_irq.sv
module urf_tx_irq
    import urf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_data,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              tx_en,
    input  logic              tx_ie,
    input  logic              rx_stored,
    input  logic              rx_ie,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              irq
);

    logic tx_fire;
    logic irq_set;

    assign tx_fire = wr_data && tx_en;
    assign irq_set = (tx_fire && tx_ie) || (rx_stored && rx_ie);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_byte  <= '0;
            irq      <= 1'b0;
        end else begin
            tx_valid <= tx_fire;
            irq      <= irq_set;
            if (tx_fire) begin
                tx_byte <= wr_byte;
            end
        end
    end

endmodule

// File: rtl/urf_apb_top.sv
module urf_apb_top
    import urf_pkg::*;
#(
    parameter int ADDR_W     = 12,
    parameter int FIFO_DEPTH = 1024
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            psel,
    input  logic                            penable,
    input  logic                            pwrite,
    input  logic [ADDR_W-1:0]               paddr,
    input  logic [31:0]                     pwdata,
    output logic [31:0]                     prdata,
    output logic                            pready,
    output logic                            pslverr,
    input  logic                            rx_valid,
    input  logic [7:0]                      rx_data,
    output logic                            rx_ready,
    output logic [$clog2(FIFO_DEPTH+1)-1:0] rx_free,
    output logic                            tx_valid,
    output logic [7:0]                      tx_byte,
    output logic                            irq
);

    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

    acc_t              acc;
    logic [WORD_W-1:0] ctrl_q;
    logic              dready_q;
    logic              rx_stored;
    logic [BYTE_W-1:0] head_byte;
    logic              has_data;
    logic              drain;

    urf_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .acc     (acc)
    );

    assign rx_ready  = (rx_free != '0);
    assign rx_stored = rx_valid && rx_ready && ctrl_q[CB_RX_EN];

    urf_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (rx_stored),
        .push_byte (rx_data),
        .pop       (acc.rd_data),
        .head_byte (head_byte),
        .has_data  (has_data),
        .drain     (drain),
        .free      (rx_free)
    );

    urf_tx_irq u_txi (
        .clk       (clk),
        .rst       (rst),
        .wr_data   (acc.wr_data),
        .wr_byte   (pwdata[BYTE_W-1:0]),
        .tx_en     (ctrl_q[CB_TX_EN]),
        .tx_ie     (ctrl_q[CB_TX_IE]),
        .rx_stored (rx_stored),
        .rx_ie     (ctrl_q[CB_RX_IE]),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .irq       (irq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (acc.wr_ctrl) begin
            ctrl_q <= pwdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dready_q <= 1'b0;
        end else if (rx_stored) begin
            dready_q <= 1'b1;
        end else if (acc.rd_data && (!has_data || drain)) begin
            dready_q <= 1'b0;
        end
    end

    always_comb begin
        prdata = '0;
        if (acc.rd_strobe) begin
            case (acc.sel)
                SEL_DATA: prdata = {{(WORD_W-BYTE_W){1'b0}}, head_byte};
                SEL_STAT: prdata = build_status(dready_q);
                SEL_CTRL: prdata = ctrl_q;
                default:  prdata = '0;
            endcase
        end
    end

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

endmodule

// File: rtl/urf_checker.sv
module urf_checker #(
    parameter int DEPTH = 1024,
    parameter int CNT_W = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             psel,
    input logic             penable,
    input logic             pwrite,
    input logic [7:0]       paddr8,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic [CNT_W-1:0] rx_free,
    input logic             tx_valid,
    input logic             irq,
    input logic [31:0]      ctrl_q,
    input logic             dready_q
);

    logic is_data, acc_rd_data, acc_wr_data, acc_wr_ctrl, stored;

    assign is_data     = (paddr8 == 8'h00) || (paddr8 == 8'h03);
    assign acc_rd_data = psel && penable && !pwrite && is_data;
    assign acc_wr_data = psel && penable &&  pwrite && is_data;
    assign acc_wr_ctrl = psel && penable &&  pwrite && (paddr8 == 8'h08);
    assign stored      = rx_valid && rx_ready && ctrl_q[0];

    // R2: control changes only through a control write
    p_ctrl_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !acc_wr_ctrl |=> $stable(ctrl_q));

    // R4: a stored byte without a concurrent read costs one slot
    p_fill_step_r4: assert property (@(posedge clk) disable iff (rst)
        (stored && !acc_rd_data) |=> (rx_free == $past(rx_free) - CNT_W'(1)));

    // R6: no waiting data means the queue has been reset to full space
    p_drained_r6: assert property (@(posedge clk) disable iff (rst)
        !dready_q |-> (rx_free == CNT_W'(DEPTH)));

    // R9: every strobe traces back to an enabled data write
    p_tx_cause_r9: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> $past(acc_wr_data && ctrl_q[1]));

    // R10: every interrupt pulse has an enabled cause one cycle earlier
    p_irq_cause_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past((stored && ctrl_q[2]) || (acc_wr_data && ctrl_q[1] && ctrl_q[3])));

endmodule

bind urf_apb_top urf_checker #(
    .DEPTH (FIFO_DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr8   (paddr[7:0]),
    .rx_valid (rx_valid),
    .rx_ready (rx_ready),
    .rx_free  (rx_free),
    .tx_valid (tx_valid),
    .irq      (irq),
    .ctrl_q   (ctrl_q),
    .dready_q (dready_q)
);

// File: tb/sim_urf_apb_top.sv
module sim_urf_apb_top;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 1024;
    localparam int AW         = 12;
    localparam int CW         = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [31:0]   pwdata = '0;
    logic [31:0]   prdata;
    logic          pready, pslverr;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_ready;
    logic [CW-1:0] rx_free;
    logic          tx_valid;
    logic [7:0]    tx_byte;
    logic          irq;

    urf_apb_top #(.ADDR_W(AW), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
        .pslverr(pslverr), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_ready(rx_ready), .rx_free(rx_free), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [7:0]  q[$];
    int          consumed = 0;
    logic [31:0] m_ctrl = '0;
    bit          m_irq = 1'b0, m_txv = 1'b0;
    logic [7:0]  m_txb = '0;

    function automatic int m_free();
        return DEPTH - (q.size() + consumed);
    endfunction

    function automatic logic [31:0] m_read(input logic [AW-1:0] a);
        logic [7:0] o;
        o = a[7:0];
        if (o == 8'h00 || o == 8'h03) return (q.size() > 0) ? {24'h0, q[0]} : 32'h0;
        if (o == 8'h04) return {29'h0, 2'b11, (q.size() > 0)};
        if (o == 8'h08) return m_ctrl;
        return 32'h0;
    endfunction

    always @(posedge clk) begin
        bit acc, isdata, rdd, wrd, wrc, store;
        if (rst) begin
            q.delete();
            consumed = 0;
            m_ctrl   = '0;
            m_irq    = 1'b0;
            m_txv    = 1'b0;
        end else begin
            acc    = psel && penable;
            isdata = (paddr[7:0] == 8'h00) || (paddr[7:0] == 8'h03);
            rdd    = acc && !pwrite && isdata;
            wrd    = acc && pwrite && isdata;
            wrc    = acc && pwrite && (paddr[7:0] == 8'h08);
            store  = rx_valid && (m_free() != 0) && m_ctrl[0];
            m_irq  = (store && m_ctrl[2]) || (wrd && m_ctrl[1] && m_ctrl[3]);
            m_txv  = wrd && m_ctrl[1];
            if (m_txv) m_txb = pwdata[7:0];
            if (rdd && q.size() > 0) begin
                void'(q.pop_front());
                consumed++;
                if (q.size() == 0) consumed = 0;
            end
            if (store) q.push_back(rx_data);
            if (wrc) m_ctrl = pwdata;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        #(CLK_PERIOD/4);
        if (!rst && !done) begin
            chk("R8 rx_ready", {31'h0, rx_ready}, {31'h0, (m_free() != 0)});
            chk("R6 rx_free", {{(32-CW){1'b0}}, rx_free}, m_free());
            chk("R10 irq", {31'h0, irq}, {31'h0, m_irq});
            chk("R9 tx_valid", {31'h0, tx_valid}, {31'h0, m_txv});
            if (m_txv) chk("R9 tx_byte", {24'h0, tx_byte}, {24'h0, m_txb});
            chk("R12 pready/pslverr", {30'h0, pready, pslverr}, 32'h2);
            if (psel && penable && !pwrite) begin
                string tag;
                if (paddr[AW-1:8] != '0)                                    tag = "R11 aliased read";
                else if ((paddr[7:0] == 0 || paddr[7:0] == 3) && q.size() == 0) tag = "R7 empty data read";
                else if (paddr[7:0] == 0 || paddr[7:0] == 3)                  tag = "R5 data read";
                else if (paddr[7:0] == 8'h04)                                 tag = "R4 status read";
                else if (paddr[7:0] == 8'h08)                                 tag = "R2 control read";
                else                                                          tag = "R3 inert read";
                chk(tag, prdata, m_read(paddr));
            end
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic apb_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_rd(input logic [AW-1:0] a, output logic [31:0] d);
        @(negedge clk); psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1;
        #(CLK_PERIOD/4 + 1); d = prdata;
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        @(negedge clk); rx_valid = 1'b1; rx_data = d;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired (all requirements) actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        #(CLK_PERIOD/4);
        // R1: reset state at the ports
        chk("R1 rx_free", {{(32-CW){1'b0}}, rx_free}, DEPTH);
        chk("R1 irq/tx_valid", {30'h0, irq, tx_valid}, 32'h0);
        apb_rd(12'h004, v); chk("R1 status", v, 32'h6);
        apb_rd(12'h008, v); chk("R1 control", v, 32'h0);

        // R2: control readback
        apb_wr(12'h008, 32'hFFFF_FFF0); apb_rd(12'h008, v); chk("R2 all-ones", v, 32'hFFFF_FFF0);
        apb_wr(12'h008, 32'h8000_1230); apb_rd(12'h008, v); chk("R2 mixed", v, 32'h8000_1230);

        // R3: inert registers
        apb_wr(12'h004, 32'hFFFF_FFFF); apb_rd(12'h004, v); chk("R3 status unwritten", v, 32'h6);
        apb_wr(12'h00C, 32'h0000_ABCD); apb_rd(12'h00C, v); chk("R3 scaler", v, 32'h0);
        apb_wr(12'h010, 32'h1234_5678); apb_rd(12'h010, v); chk("R3 debug slot", v, 32'h0);
        apb_wr(12'h014, 32'hFFFF_FFFF); apb_rd(12'h014, v); chk("R3 unmapped", v, 32'h0);
        apb_rd(12'h008, v); chk("R3 control untouched", v, 32'h8000_1230);

        // R4: receive disabled, bytes dropped
        apb_wr(12'h008, 32'h0);
        push(8'hA1); push(8'hA2);
        #(CLK_PERIOD/4);
        chk("R4 dropped while disabled", {{(32-CW){1'b0}}, rx_free}, DEPTH);

        // R4/R5/R6/R10: burst with rx irq, partial drain via both offsets
        apb_wr(12'h008, 32'h5);
        for (int i = 0; i < 5; i++) push(8'h30 + 8'(i));
        apb_rd(12'h004, v); chk("R4 data ready", v, 32'h7);
        apb_rd(12'h000, v); chk("R5 first", v, 32'h30);
        apb_rd(12'h003, v); chk("R5 offset 3", v, 32'h31);
        apb_rd(12'h000, v); chk("R5 third", v, 32'h32);
        #(CLK_PERIOD/4);
        chk("R6 no reclaim", {{(32-CW){1'b0}}, rx_free}, DEPTH - 5);
        apb_rd(12'h000, v); chk("R5 fourth", v, 32'h33);
        apb_rd(12'h003, v); chk("R5 last", v, 32'h34);
        #(CLK_PERIOD/4);
        chk("R6 flushed", {{(32-CW){1'b0}}, rx_free}, DEPTH);
        apb_rd(12'h004, v); chk("R6 ready cleared", v, 32'h6);
        apb_rd(12'h000, v); chk("R7 empty read", v, 32'h0);
        apb_rd(12'h004, v); chk("R7 ready stays clear", v, 32'h6);

        // R6: arrival in the same cycle as the draining read
        push(8'h11);
        fork
            apb_rd(12'h000, v);
            begin
                @(negedge clk);
                @(negedge clk); rx_valid = 1'b1; rx_data = 8'h22;
                @(negedge clk); rx_valid = 1'b0;
            end
        join
        chk("R6 drain read", v, 32'h11);
        apb_rd(12'h000, v); chk("R6 byte kept across flush", v, 32'h22);

        // R9/R10: transmit with enable combinations
        apb_wr(12'h008, 32'h2);  apb_wr(12'h000, 32'h0000_01A5);
        apb_wr(12'h008, 32'hA);  apb_wr(12'h003, 32'h0000_003C);
        apb_wr(12'h008, 32'h8);  apb_wr(12'h000, 32'h0000_0077);
        apb_wr(12'h008, 32'h0);  apb_wr(12'h000, 32'h0000_0055);

        // R11: aliasing above bit 7
        apb_wr(12'h108, 32'h0000_0C03); apb_rd(12'h208, v); chk("R11 control alias", v, 32'h0000_0C03);
        apb_rd(12'hF04, v); chk("R11 status alias", v, 32'h6);

        // R8: overfill with a continuous stream, then drain
        apb_wr(12'h008, 32'h1);
        for (int i = 0; i < DEPTH + 4; i++) begin
            @(negedge clk); rx_valid = 1'b1; rx_data = 8'(i);
        end
        @(negedge clk); rx_valid = 1'b0;
        #(CLK_PERIOD/4);
        chk("R8 full blocks", {31'h0, rx_ready}, 32'h0);
        apb_rd(12'h000, v); chk("R5 full first", v, 32'h0);
        #(CLK_PERIOD/4);
        chk("R8 still blocked after partial read", {31'h0, rx_ready}, 32'h0);
        for (int i = 1; i < DEPTH; i++) begin
            apb_rd(12'h000, v);
            chk("R5 full drain", v, {24'h0, 8'(i)});
        end
        #(CLK_PERIOD/4);
        chk("R6 full flushed", {{(32-CW){1'b0}}, rx_free}, DEPTH);

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule